// File: doc/BRIEF.md
# Streaming Link Statistics Collector

This block collects performance figures for a streaming data link. It watches the one-cycle event pulses from the transmit packetizer and the receive depacketizer. It counts frames sent, frames received, frames reported lost and blocks reported lost. A lost-frames event comes with a count of the frames missing, and that count is added to the lost-frame total. A lost-block event adds one.

On every valid latency sample, the block updates a running minimum and a running maximum. It also adds the sample to a wide accumulator and increments a sample counter. Software can divide the accumulator by the sample count to get an average latency.

Every figure is a registered parallel output, meant to feed an external register file. A synchronous clear-statistics input returns all figures to their reset values. No counter ever wraps; each one stops at its all-ones value.

Top module: `link_stats_collector`

## Requirements
- R1: After reset, the following outputs read zero: the four event counters, the maximum latency, the accumulator and the sample counter. The minimum latency reads all ones.
- R2: Each cycle with `tx_frame_i` high adds one to `tx_frames_o`. The new value appears on the cycle after that edge.
- R3: Each cycle with `rx_frame_i` high adds one to `rx_frames_o`.
- R4: Each cycle with `lost_blk_i` high adds one to `lost_blocks_o`.
- R5: Each cycle with `lost_frm_i` high adds the value of `lost_frm_cnt_i` to `lost_frames_o`. When `lost_frm_i` is low, `lost_frm_cnt_i` has no effect.
- R6: When `lat_valid_i` is high and `lat_i` is below `lat_min_o`, the minimum takes the value of `lat_i`.
- R7: When `lat_valid_i` is high and `lat_i` is above `lat_max_o`, the maximum takes the value of `lat_i`.
- R8: When `lat_valid_i` is high, `lat_i` is added to `lat_acc_o` and `lat_samples_o` goes up by one, in the same cycle.
- R9: When `lat_valid_i` is low, `lat_i` has no effect. Minimum, maximum, accumulator and sample count all hold their values.
- R10: Every counter and the accumulator saturate at all ones and do not wrap. This holds when a single lost-frames addition overshoots the limit.
- R11: `clr_stats_i` high returns all outputs to their R1 values on the next cycle. Clearing takes priority: any event in the same cycle is discarded.
- R12: Events that arrive in the same cycle are all counted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_stats_i | input | 1 | Synchronous clear of all statistics |
| tx_frame_i | input | 1 | Frame transmitted pulse |
| rx_frame_i | input | 1 | Frame received pulse |
| lost_blk_i | input | 1 | Blocks lost pulse |
| lost_frm_i | input | 1 | Frames lost pulse |
| lost_frm_cnt_i | input | CNT_W | Number of frames lost, qualified by lost_frm_i |
| lat_valid_i | input | 1 | Latency sample valid |
| lat_i | input | LAT_W | Latency sample in reference clock cycles |
| tx_frames_o | output | CNT_W | Transmitted frame count |
| rx_frames_o | output | CNT_W | Received frame count |
| lost_frames_o | output | CNT_W | Lost frame total |
| lost_blocks_o | output | CNT_W | Lost block count |
| lat_min_o | output | LAT_W | Smallest latency seen |
| lat_max_o | output | LAT_W | Largest latency seen |
| lat_acc_o | output | ACC_W | Sum of latency samples |
| lat_samples_o | output | CNT_W | Number of latency samples |

## Verification
The assertions check several things on every cycle:
- clear forces the reset values;
- the transmit counter never decreases and stays stable when no pulse is present;
- the lost-frame total stays stable when no lost-frames pulse is present;
- the latency figures stay frozen when no valid sample is present;
- once a sample exists, the minimum never exceeds the maximum.

The exact sums need the bench's scenarios, which use known input values. These cover added lost-frame counts, the min/max choice across an ordered sample set, accumulator totals, saturation at the limit, and clear-versus-event priority.

// File: rtl/link_stats_pkg.sv
package link_stats_pkg;
  localparam int EV_TX      = 0;
  localparam int EV_RX      = 1;
  localparam int EV_LOSTFRM = 2;
  localparam int EV_LOSTBLK = 3;
  localparam int N_EV       = 4;
endpackage

// File: rtl/stat_sat_ctr.sv
module stat_sat_ctr #(
  parameter int W  = 16,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  q_o
);
  logic [W:0] sum;

  assign sum = {1'b0, q_o} + (W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clr_i)   q_o <= '0;
    else if (en_i)    q_o <= sum[W] ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/stat_lat_track.sv
module stat_lat_track #(
  parameter int LAT_W = 28,
  parameter int ACC_W = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [LAT_W-1:0] min_o,
  output logic [LAT_W-1:0] max_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_o <= '1;
      max_o <= '0;
    end else if (clr_i) begin
      min_o <= '1;
      max_o <= '0;
    end else if (valid_i) begin
      if (lat_i < min_o) min_o <= lat_i;
      if (lat_i > max_o) max_o <= lat_i;
    end
  end

  stat_sat_ctr #(.W(ACC_W), .IW(LAT_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (valid_i),
    .inc_i  (lat_i),
    .q_o    (acc_o)
  );

  stat_sat_ctr #(.W(CNT_W), .IW(1)) u_samples (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (valid_i),
    .inc_i  (1'b1),
    .q_o    (cnt_o)
  );
endmodule

// File: rtl/link_stats_collector.sv
module link_stats_collector
  import link_stats_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ACC_W = 64,
  parameter int LAT_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_stats_i,
  input  logic             tx_frame_i,
  input  logic             rx_frame_i,
  input  logic             lost_blk_i,
  input  logic             lost_frm_i,
  input  logic [CNT_W-1:0] lost_frm_cnt_i,
  input  logic             lat_valid_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [CNT_W-1:0] tx_frames_o,
  output logic [CNT_W-1:0] rx_frames_o,
  output logic [CNT_W-1:0] lost_frames_o,
  output logic [CNT_W-1:0] lost_blocks_o,
  output logic [LAT_W-1:0] lat_min_o,
  output logic [LAT_W-1:0] lat_max_o,
  output logic [ACC_W-1:0] lat_acc_o,
  output logic [CNT_W-1:0] lat_samples_o
);
  logic [N_EV-1:0]  ev_en;
  logic [CNT_W-1:0] ev_inc [N_EV];
  logic [CNT_W-1:0] ev_cnt [N_EV];

  assign ev_en[EV_TX]      = tx_frame_i;
  assign ev_en[EV_RX]      = rx_frame_i;
  assign ev_en[EV_LOSTFRM] = lost_frm_i;
  assign ev_en[EV_LOSTBLK] = lost_blk_i;

  assign ev_inc[EV_TX]      = CNT_W'(1);
  assign ev_inc[EV_RX]      = CNT_W'(1);
  assign ev_inc[EV_LOSTFRM] = lost_frm_cnt_i;
  assign ev_inc[EV_LOSTBLK] = CNT_W'(1);

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    stat_sat_ctr #(.W(CNT_W), .IW(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_stats_i),
      .en_i   (ev_en[g]),
      .inc_i  (ev_inc[g]),
      .q_o    (ev_cnt[g])
    );
  end

  assign tx_frames_o   = ev_cnt[EV_TX];
  assign rx_frames_o   = ev_cnt[EV_RX];
  assign lost_frames_o = ev_cnt[EV_LOSTFRM];
  assign lost_blocks_o = ev_cnt[EV_LOSTBLK];

  stat_lat_track #(.LAT_W(LAT_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_lat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_stats_i),
    .valid_i (lat_valid_i),
    .lat_i   (lat_i),
    .min_o   (lat_min_o),
    .max_o   (lat_max_o),
    .acc_o   (lat_acc_o),
    .cnt_o   (lat_samples_o)
  );
endmodule

// File: rtl/link_stats_collector_chk.sv
module link_stats_collector_chk #(
  parameter int CNT_W = 16,
  parameter int ACC_W = 64,
  parameter int LAT_W = 28
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_stats_i,
  input logic             tx_frame_i,
  input logic             lost_frm_i,
  input logic             lat_valid_i,
  input logic [CNT_W-1:0] tx_frames_o,
  input logic [CNT_W-1:0] rx_frames_o,
  input logic [CNT_W-1:0] lost_frames_o,
  input logic [CNT_W-1:0] lost_blocks_o,
  input logic [LAT_W-1:0] lat_min_o,
  input logic [LAT_W-1:0] lat_max_o,
  input logic [ACC_W-1:0] lat_acc_o,
  input logic [CNT_W-1:0] lat_samples_o
);
  // R11
  clear_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stats_i |=> (tx_frames_o == '0 && rx_frames_o == '0 && lost_frames_o == '0 &&
                     lost_blocks_o == '0 && lat_min_o == '1 && lat_max_o == '0 &&
                     lat_acc_o == '0 && lat_samples_o == '0));

  // R10
  tx_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_stats_i |=> tx_frames_o >= $past(tx_frames_o));

  // R2
  tx_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_stats_i && !tx_frame_i) |=> $stable(tx_frames_o));

  // R5
  lost_frm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_stats_i && !lost_frm_i) |=> $stable(lost_frames_o));

  // R9
  lat_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_stats_i && !lat_valid_i) |=> ($stable(lat_min_o) && $stable(lat_max_o) &&
                                        $stable(lat_acc_o) && $stable(lat_samples_o)));

  // R6
  min_le_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_samples_o != '0) |-> (lat_min_o <= lat_max_o));
endmodule

bind link_stats_collector link_stats_collector_chk #(
  .CNT_W(CNT_W), .ACC_W(ACC_W), .LAT_W(LAT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clr_stats_i   (clr_stats_i),
  .tx_frame_i    (tx_frame_i),
  .lost_frm_i    (lost_frm_i),
  .lat_valid_i   (lat_valid_i),
  .tx_frames_o   (tx_frames_o),
  .rx_frames_o   (rx_frames_o),
  .lost_frames_o (lost_frames_o),
  .lost_blocks_o (lost_blocks_o),
  .lat_min_o     (lat_min_o),
  .lat_max_o     (lat_max_o),
  .lat_acc_o     (lat_acc_o),
  .lat_samples_o (lat_samples_o)
);

// File: tb/link_stats_collector_bench.sv
module link_stats_collector_bench;
  localparam int CNT_W = 16;
  localparam int ACC_W = 64;
  localparam int LAT_W = 28;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_stats_i = 1'b0, tx_frame_i = 1'b0, rx_frame_i = 1'b0;
  logic lost_blk_i = 1'b0, lost_frm_i = 1'b0, lat_valid_i = 1'b0;
  logic [CNT_W-1:0] lost_frm_cnt_i = '0;
  logic [LAT_W-1:0] lat_i = '0;
  logic [CNT_W-1:0] tx_frames_o, rx_frames_o, lost_frames_o, lost_blocks_o, lat_samples_o;
  logic [LAT_W-1:0] lat_min_o, lat_max_o;
  logic [ACC_W-1:0] lat_acc_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  link_stats_collector #(.CNT_W(CNT_W), .ACC_W(ACC_W), .LAT_W(LAT_W)) u_link_stats_collector (
    .clk_i, .rst_ni, .clr_stats_i, .tx_frame_i, .rx_frame_i, .lost_blk_i, .lost_frm_i,
    .lost_frm_cnt_i, .lat_valid_i, .lat_i, .tx_frames_o, .rx_frames_o, .lost_frames_o,
    .lost_blocks_o, .lat_min_o, .lat_max_o, .lat_acc_o, .lat_samples_o
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_all();
    clr_stats_i = 0; tx_frame_i = 0; rx_frame_i = 0; lost_blk_i = 0;
    lost_frm_i = 0; lat_valid_i = 0;
  endtask

  // one cycle of stimulus, then sample on the following falling edge
  task automatic step();
    @(negedge clk_i);
    idle_all();
  endtask

  task automatic do_clear();
    @(negedge clk_i); clr_stats_i = 1; step();
  endtask

  task automatic check_cleared(input string req);
    chk(req, "tx", 64'(tx_frames_o), 0);
    chk(req, "rx", 64'(rx_frames_o), 0);
    chk(req, "lostfrm", 64'(lost_frames_o), 0);
    chk(req, "lostblk", 64'(lost_blocks_o), 0);
    chk(req, "min", 64'(lat_min_o), 64'({LAT_W{1'b1}}));
    chk(req, "max", 64'(lat_max_o), 0);
    chk(req, "acc", lat_acc_o, 0);
    chk(req, "samples", 64'(lat_samples_o), 0);
  endtask

  task automatic t_reset();
    check_cleared("R1");
  endtask

  task automatic t_events();
    do_clear();
    for (int i = 0; i < 3; i++) begin @(negedge clk_i); tx_frame_i = 1; step(); end
    for (int i = 0; i < 2; i++) begin @(negedge clk_i); rx_frame_i = 1; step(); end
    @(negedge clk_i); lost_blk_i = 1; step();
    chk("R2", "tx after 3", 64'(tx_frames_o), 3);
    chk("R3", "rx after 2", 64'(rx_frames_o), 2);
    chk("R4", "lostblk after 1", 64'(lost_blocks_o), 1);
  endtask

  task automatic t_lost_frames();
    do_clear();
    @(negedge clk_i); lost_frm_i = 1; lost_frm_cnt_i = 5; step();
    chk("R5", "lostfrm +5", 64'(lost_frames_o), 5);
    @(negedge clk_i); lost_frm_i = 1; lost_frm_cnt_i = 7; step();
    chk("R5", "lostfrm +7", 64'(lost_frames_o), 12);
    @(negedge clk_i); lost_frm_cnt_i = 9; step();
    chk("R5", "count without pulse", 64'(lost_frames_o), 12);
  endtask

  task automatic t_latency();
    do_clear();
    @(negedge clk_i); lat_valid_i = 1; lat_i = 100; step();
    chk("R6", "min first", 64'(lat_min_o), 100);
    chk("R7", "max first", 64'(lat_max_o), 100);
    @(negedge clk_i); lat_valid_i = 1; lat_i = 40; step();
    @(negedge clk_i); lat_valid_i = 1; lat_i = 250; step();
    chk("R6", "min", 64'(lat_min_o), 40);
    chk("R7", "max", 64'(lat_max_o), 250);
    chk("R8", "acc", lat_acc_o, 390);
    chk("R8", "samples", 64'(lat_samples_o), 3);
    @(negedge clk_i); lat_i = 5; step();
    @(negedge clk_i); lat_i = 999; step();
    chk("R9", "min hold", 64'(lat_min_o), 40);
    chk("R9", "max hold", 64'(lat_max_o), 250);
    chk("R9", "acc hold", lat_acc_o, 390);
    chk("R9", "samples hold", 64'(lat_samples_o), 3);
  endtask

  task automatic t_simultaneous();
    do_clear();
    @(negedge clk_i);
    tx_frame_i = 1; rx_frame_i = 1; lost_blk_i = 1; lost_frm_i = 1; lost_frm_cnt_i = 3;
    lat_valid_i = 1; lat_i = 77;
    step();
    chk("R12", "tx", 64'(tx_frames_o), 1);
    chk("R12", "rx", 64'(rx_frames_o), 1);
    chk("R12", "lostblk", 64'(lost_blocks_o), 1);
    chk("R12", "lostfrm", 64'(lost_frames_o), 3);
    chk("R12", "samples", 64'(lat_samples_o), 1);
  endtask

  task automatic t_clear_priority();
    @(negedge clk_i);
    clr_stats_i = 1; tx_frame_i = 1; rx_frame_i = 1; lost_blk_i = 1; lost_frm_i = 1;
    lost_frm_cnt_i = 4; lat_valid_i = 1; lat_i = 10;
    step();
    check_cleared("R11");
    @(negedge clk_i); tx_frame_i = 1; step();
    chk("R11", "count after clear", 64'(tx_frames_o), 1);
  endtask

  task automatic t_saturation();
    do_clear();
    @(negedge clk_i); lost_frm_i = 1; lost_frm_cnt_i = 16'hFFF0; step();
    @(negedge clk_i); lost_frm_i = 1; lost_frm_cnt_i = 16'h0020; step();
    chk("R10", "lostfrm saturate", 64'(lost_frames_o), 64'hFFFF);
    @(negedge clk_i); tx_frame_i = 1;
    repeat (65540) @(negedge clk_i);
    idle_all();
    chk("R10", "tx saturate", 64'(tx_frames_o), 64'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_events();
    t_lost_frames();
    t_latency();
    t_simultaneous();
    t_clear_priority();
    t_saturation();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule